// File: doc/BRIEF.md
# Configurable External Interrupt Unit

This block accepts a bank of asynchronous interrupt wires from outside the chip and presents one active-high level per line to a downstream interrupt controller. Each line is configured on its own: it can watch for a level or for a transition, and it can treat high/rising or low/falling as the active condition. Whatever the configuration, the line's output is a plain active-high level.

Every detected event is captured in a per-line sticky request. A per-line mask gates the request onto the output, and software removes requests by writing ones to a clear register. Level-sensitive lines are captured as well, so they also need an explicit clear. A clear issued while the level is still active leaves the request in place. Requests are captured even while a line is masked, so a request can already be pending when the line is unmasked.

Each line holds a two-state machine. LN_IDLE moves to LN_PENDING on the *latch* transition, when a qualified event is seen. LN_PENDING moves back to LN_IDLE on the *release* transition, when a clear arrives in a cycle with no qualified event. In every other case a line stays in its current state. Configuration and status use a simple register port with a valid/write strobe, a byte address and 32-bit word data. Reads return data combinationally in the same cycle.

Top module: `ext_irq_unit`

## Requirements
- R1: While reset is held, the mask word reads all ones. The raw status, polarity, sense, source-select and spare words read zero, and every output is low.
- R2: The word decode uses byte address bits [4:2]. The offsets are: 0x00 mask, 0x04 source select, 0x08 masked status (read-only), 0x0C raw status (read-only), 0x10 clear (write-only, reads zero), 0x14 polarity, 0x18 sense, 0x1C spare. Source select and spare are plain read/write storage. A write to a read-only word changes nothing.
- R3: A line with polarity bit 1 and sense bit 0 (high level) captures a request while its input is high. The request stays set after the input falls, until it is cleared.
- R4: A line with polarity bit 0 and sense bit 0 (low level) captures a request while its input is low.
- R5: A line with polarity bit 1 and sense bit 1 captures a request only on a 0-to-1 input transition. A steady input does not set it again after a clear.
- R6: A line with polarity bit 0 and sense bit 1 captures a request only on a 1-to-0 input transition.
- R7: Writing the clear word removes the request of each line whose data bit is 1. Lines whose bit is 0 keep their requests.
- R8: A clear that reaches a level-sensitive line while its input is still active leaves the request set, visible in the first read after the write.
- R9: A mask bit of 1 forces that line's output low. Requests are still captured while masked, and a pending request drives the output as soon as its mask bit is written to 0. Masked status equals raw status AND NOT mask.
- R10: Each output is active-high and equals the corresponding masked status bit, for every polarity and sense setting.
- R11: An input change passes through a two-flop synchroniser. For an edge-sensitive line, the request is not visible after two rising clock edges and is visible after the third.
- R12: When a clear and a new event meet on the same line in the same cycle, the request stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | External interrupt wires, asynchronous |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address of the word |
| reg_wdata | input | NLINES | Write data |
| reg_rdata | output | NLINES | Read data, zero unless a read is strobed |
| irq_out | output | NLINES | Active-high level per line to the downstream controller |

## Verification
A line state machine stuck in, or wrongly entering, LN_PENDING shows up directly in the raw status word and, once unmasked, on `irq_out`. This happens on the edge that makes the wrong transition, so the bench reads status in the first half-cycle after each clear or event. A wrong detector or synchroniser depth shifts the capture edge away from the third clock after an input change, or captures the wrong polarity. Each polarity/sense pairing is driven through all four before/after input combinations to expose this. A wrong priority between clear and event is caught by aligning a clear write with a synchronised edge to the exact cycle.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    typedef enum logic {
        LN_IDLE    = 1'b0,
        LN_PENDING = 1'b1
    } line_state_e;

    typedef enum logic [2:0] {
        W_MASK  = 3'd0,
        W_SEL   = 3'd1,
        W_MSTAT = 3'd2,
        W_RAW   = 3'd3,
        W_CLR   = 3'd4,
        W_POL   = 3'd5,
        W_SENSE = 3'd6,
        W_SPARE = 3'd7
    } word_e;

endpackage

// File: rtl/eiu_sync.sv
module eiu_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eiu_line.sv
module eiu_line
    import eiu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pol,
    input  logic sense,
    input  logic clr,
    output logic req
);
    line_state_e state_q, state_d;
    logic prev_q;
    logic active, was_active, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    always_comb begin
        active     = pol ? sync_in : ~sync_in;
        was_active = pol ? prev_q  : ~prev_q;
        hit        = sense ? (active & ~was_active) : active;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE:    if (hit)         state_d = LN_PENDING;
            LN_PENDING: if (clr && !hit) state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    always_comb req = (state_q == LN_PENDING);

    a_r3_request_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr) |=> req);
    a_r8_level_clear_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!sense && active && clr) |=> req);
    a_r12_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && clr) |=> req);
    a_r7_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (req && clr && !hit) |=> !req);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !hit) |=> !req);
endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [4:0]        reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    input  logic [NLINES-1:0] raw_i,
    output logic [NLINES-1:0] mask_o,
    output logic [NLINES-1:0] pol_o,
    output logic [NLINES-1:0] sense_o,
    output logic [NLINES-1:0] clr_o
);
    logic [NLINES-1:0] mask_q, sel_q, pol_q, sense_q, spare_q;
    word_e             word;
    logic              wr_en, rd_en;
    wire               unused_lsb = &{1'b0, reg_addr[1:0]};

    always_comb begin
        word  = word_e'(reg_addr[4:2]);
        wr_en = reg_valid && reg_write;
        rd_en = reg_valid && !reg_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            sel_q   <= '0;
            pol_q   <= '0;
            sense_q <= '0;
            spare_q <= '0;
        end else if (wr_en) begin
            unique case (word)
                W_MASK:  mask_q  <= reg_wdata;
                W_SEL:   sel_q   <= reg_wdata;
                W_POL:   pol_q   <= reg_wdata;
                W_SENSE: sense_q <= reg_wdata;
                W_SPARE: spare_q <= reg_wdata;
                W_MSTAT, W_RAW, W_CLR: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            unique case (word)
                W_MASK:  reg_rdata = mask_q;
                W_SEL:   reg_rdata = sel_q;
                W_MSTAT: reg_rdata = raw_i & ~mask_q;
                W_RAW:   reg_rdata = raw_i;
                W_CLR:   reg_rdata = '0;
                W_POL:   reg_rdata = pol_q;
                W_SENSE: reg_rdata = sense_q;
                W_SPARE: reg_rdata = spare_q;
            endcase
        end
    end

    always_comb begin
        clr_o   = (wr_en && word == W_CLR) ? reg_wdata : '0;
        mask_o  = mask_q;
        pol_o   = pol_q;
        sense_o = sense_q;
    end

    a_r2_clear_word_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && word == W_CLR) |-> (reg_rdata == '0));
    a_r9_mask_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word == W_MASK) |=> (mask_o == $past(reg_wdata)));
    a_r2_readonly_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (word == W_RAW || word == W_MSTAT)) |=>
        ($stable(mask_o) && $stable(pol_o) && $stable(sense_o)));
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [4:0]        reg_addr,
    input  logic [NLINES-1:0] reg_wdata,
    output logic [NLINES-1:0] reg_rdata,
    output logic [NLINES-1:0] irq_out
);
    localparam int SYNC_STAGES = 2;

    logic [NLINES-1:0] synced, raw, mask, pol, sense, clr;

    eiu_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (synced)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        eiu_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (synced[i]),
            .pol     (pol[i]),
            .sense   (sense[i]),
            .clr     (clr[i]),
            .req     (raw[i])
        );
    end

    eiu_regs #(.NLINES(NLINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .raw_i     (raw),
        .mask_o    (mask),
        .pol_o     (pol),
        .sense_o   (sense),
        .clr_o     (clr)
    );

    assign irq_out = raw & ~mask;

    a_r9_masked_line_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & mask) == '0);
endmodule

// File: tb/ext_irq_unit_tb.sv
module ext_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [4:0] A_MASK = 5'h00, A_SEL = 5'h04, A_MSTAT = 5'h08,
                           A_RAW = 5'h0C, A_CLR = 5'h10, A_POL = 5'h14,
                           A_SENSE = 5'h18, A_SPARE = 5'h1C;
    // {pol, sense, before, after, expected raw bit}
    localparam logic [4:0] VEC [16] = '{
        5'b10_00_0, 5'b10_01_1, 5'b10_10_1, 5'b10_11_1,
        5'b00_00_1, 5'b00_01_1, 5'b00_10_1, 5'b00_11_0,
        5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_0,
        5'b01_00_0, 5'b01_01_0, 5'b01_10_1, 5'b01_11_0
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0] irq_in = '0, reg_wdata = '0, reg_rdata, irq_out;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [4:0] reg_addr = '0;
    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_unit #(.NLINES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string rq, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [N-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic chk_rd(input logic [4:0] a, input logic [N-1:0] exp, input string rq);
        logic [N-1:0] v;
        rd(a, v);
        check(v === exp, rq, v, exp);
    endtask

    task automatic chk_bit(input logic [4:0] a, input int ln, input logic exp, input string rq);
        logic [N-1:0] v;
        rd(a, v);
        check(v[ln] === exp, rq, {31'b0, v[ln]}, {31'b0, exp});
    endtask

    task automatic quiesce();
        wr(A_POL, '1);
        wr(A_SENSE, '0);
        @(negedge clk) irq_in = '0;
        settle();
        wr(A_CLR, '1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        // R1: reset state while reset is held
        chk_rd(A_MASK, '1, "R1 mask");
        chk_rd(A_RAW, '0, "R1 raw");
        chk_rd(A_POL, '0, "R1 pol");
        chk_rd(A_SENSE, '0, "R1 sense");
        chk_rd(A_SEL, '0, "R1 sel");
        chk_rd(A_SPARE, '0, "R1 spare");
        @(negedge clk) check(irq_out === '0, "R1 outputs", irq_out, '0);
        @(negedge clk) rst_n = 1'b1;

        quiesce();
        chk_rd(A_RAW, '0, "R2 raw after quiesce");
        // R2: storage words and read-only words
        wr(A_SEL, 32'hA5A5_3C3C);
        chk_rd(A_SEL, 32'hA5A5_3C3C, "R2 select");
        wr(A_SPARE, 32'h1234_5678);
        chk_rd(A_SPARE, 32'h1234_5678, "R2 spare");
        wr(A_CLR, 32'h0000_0001);
        chk_rd(A_CLR, '0, "R2 clear reads zero");
        wr(A_RAW, '1);
        wr(A_MSTAT, '1);
        chk_rd(A_RAW, '0, "R2 raw read-only");
        chk_rd(A_MASK, '1, "R2 mask untouched");

        // Table walk: R3 R4 R5 R6 per polarity/sense pairing
        for (int i = 0; i < 16; i++) begin
            int ln;
            logic [N-1:0] one;
            ln = i * 2;
            one = 32'd1 << ln;
            wr(A_POL, VEC[i][4] ? '1 : ~one);
            wr(A_SENSE, VEC[i][3] ? one : '0);
            @(negedge clk) irq_in[ln] = VEC[i][2];
            settle();
            wr(A_CLR, one);
            @(negedge clk) irq_in[ln] = VEC[i][1];
            settle();
            rd(A_RAW, v);
            check(v[ln] === VEC[i][0], $sformatf("R3/R4/R5/R6 vec%0d (R3 R4 R5 R6)", i),
                  {31'b0, v[ln]}, {31'b0, VEC[i][0]});
        end
        quiesce();

        // R11: synchroniser latency on a rising-edge line 5
        wr(A_SENSE, 32'd1 << 5);
        @(negedge clk) irq_in[5] = 1'b1;
        repeat (2) @(posedge clk);
        chk_bit(A_RAW, 5, 1'b0, "R11 not yet after two edges");
        @(posedge clk);
        chk_bit(A_RAW, 5, 1'b1, "R11 set after third edge");

        // R12: clear and new event in the same cycle, line 7 rising
        wr(A_SENSE, (32'd1 << 5) | (32'd1 << 7));
        @(negedge clk) irq_in[7] = 1'b1;
        settle();
        @(negedge clk) irq_in[7] = 1'b0;
        settle();
        chk_bit(A_RAW, 7, 1'b1, "R12 pre-latched");
        @(negedge clk) irq_in[7] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = A_CLR; reg_wdata = 32'd1 << 7;
        @(posedge clk);
        @(negedge clk) begin reg_valid = 1'b0; reg_write = 1'b0; end
        chk_bit(A_RAW, 7, 1'b1, "R12 event wins over clear");
        wr(A_CLR, 32'd1 << 7);
        chk_bit(A_RAW, 7, 1'b0, "R7 clear with steady edge input");

        // R8 and R3: level-high line 9
        @(negedge clk) irq_in[9] = 1'b1;
        settle();
        wr(A_CLR, 32'd1 << 9);
        chk_bit(A_RAW, 9, 1'b1, "R8 clear while active ignored");
        @(negedge clk) irq_in[9] = 1'b0;
        settle();
        chk_bit(A_RAW, 9, 1'b1, "R3 stays after deassert");
        wr(A_CLR, 32'd1 << 9);
        chk_bit(A_RAW, 9, 1'b0, "R3 cleared after deassert");

        // R7: partial clear of lines 10 and 11
        @(negedge clk) irq_in[11:10] = 2'b11;
        settle();
        @(negedge clk) irq_in[11:10] = 2'b00;
        settle();
        wr(A_CLR, 32'd1 << 10);
        rd(A_RAW, v);
        check(v[11:10] === 2'b10, "R7 partial clear", {30'b0, v[11:10]}, 32'd2);
        wr(A_CLR, 32'd1 << 11);

        // R9: capture while masked, appears on unmask (line 3)
        @(negedge clk) irq_in[3] = 1'b1;
        settle();
        @(negedge clk) check(irq_out[3] === 1'b0, "R9 masked output low", irq_out, '0);
        chk_bit(A_MSTAT, 3, 1'b0, "R9 masked status");
        chk_bit(A_RAW, 3, 1'b1, "R9 raw captured while masked");
        @(negedge clk) irq_in[3] = 1'b0;
        settle();
        wr(A_MASK, ~(32'd1 << 3));
        @(negedge clk) check(irq_out === (32'd1 << 3), "R9 pending after unmask", irq_out, 32'd1 << 3);
        chk_bit(A_MSTAT, 3, 1'b1, "R9 masked status after unmask");
        wr(A_CLR, 32'd1 << 3);
        @(negedge clk) check(irq_out === '0, "R9 output drops after clear", irq_out, '0);

        // R10: falling-edge line 4 drives an active-high output
        wr(A_POL, ~(32'd1 << 4));
        wr(A_SENSE, 32'd1 << 4);
        @(negedge clk) irq_in[4] = 1'b1;
        settle();
        wr(A_CLR, 32'd1 << 4);
        wr(A_MASK, ~((32'd1 << 3) | (32'd1 << 4)));
        @(negedge clk) irq_in[4] = 1'b0;
        settle();
        @(negedge clk) check(irq_out === (32'd1 << 4), "R10 active-high output", irq_out, 32'd1 << 4);
        rd(A_MSTAT, v);
        check(v === irq_out, "R10 output equals masked status", irq_out, v);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule